// File: doc/BRIEF.md
# Dual-Address Serial Register Target with Input Routing

This block is a target on a two-wire serial bus (I2C protocol, up to 400 kHz SCL) that answers two separate device addresses. One is a control port: the first byte written to it sets an address pointer, and each later byte is stored in the register at the pointer. The same port can be read after a repeated START to inspect the registers. The other is a read-only readback port. It streams bytes from an external buffer interface and pops one entry for each byte it sends. A strap input picks one of two address pairs, so two of these blocks can share one bus.

The register bank drives an input-routing decoder. Three registers hold a manual routing enable and four 4-bit selector fields, one for each of four converter channels. Each field is decoded into a 6-bit one-hot select over six analog inputs. A code that is unsupported, or that names an input the channel cannot reach, yields all zeros. All zeros also results when manual routing is off.

The SCL and SDA lines are sampled with the system clock through a synchronizer. SDA is driven open-drain through an output-enable, where 1 pulls the line low.

Top module: `dual_port_i2c_target`

## Requirements
- R1: With `addr_strap`=0, the control port acknowledges address byte 0x40 (write) and 0x41 (read), and the readback port acknowledges 0x21 (read).
- R2: With `addr_strap`=1, the control port uses 0x42/0x43 and the readback port uses 0x23. The strap-0 addresses are then not acknowledged.
- R3: An address byte that matches no port, or a write byte (LSB 0) to the readback address, gets a NACK. Every later byte up to the next START is ignored and leaves the registers unchanged.
- R4: In a control write, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then increments by one.
- R5: After a repeated START, control reads return the register at the pointer and increment it. Pointers at or beyond the 16-register map read 0x00, and writes to them are dropped.
- R6: Each byte sent from the readback port is `rb_data`, sampled in the single cycle where `rb_pop` pulses. There is exactly one pulse per byte. After the controller's NACK, no further byte is fetched.
- R7: The target pulls SDA low during the ninth clock after every accepted address byte and every written data byte.
- R8: Selector code to input: 0001→1, 0010→2, 1100→3, 0100→4, 0101→5, 0110→6. Channel k is selected by register 0x0D (k=0 bits [3:0], k=1 bits [7:4]) or 0x0E (k=2 bits [3:0], k=3 bits [7:4]). Input n sets `route_out` bit 6k+n−1, and at most one bit per channel is high.
- R9: Channel 2 cannot select inputs 1 or 3, and channel 3 can select only input 4. An illegal pairing or any other code gives zero for that channel.
- R10: When register 0x0C bit 7 is 0, `route_out` is all zeros whatever the selectors hold.
- R11: A low `rst_n` at a clock edge clears every register and the pointer, zeroes `route_out` and releases SDA.
- R12: SDA is never driven while the target is idle, whether after a STOP, a NACKed address or a finished read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_strap | input | 1 | Selects the address pair |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| rb_pop | output | 1 | Pulse: readback byte taken, advance buffer |
| rb_data | input | 8 | Current readback buffer byte |
| route_out | output | 24 | One-hot input selects, 6 bits per channel |

## Verification
START/STOP recognition and the byte engine's bit-edge work can meet at the same moment. A repeated START arrives just after the target has ended the acknowledge of a pointer byte. A STOP follows directly on a controller NACK that ends a readback burst. The bench sends a pointer byte, restarts at once and reads the control port. Correct handling is judged by the bytes returned against a behavioural register model. It also ends readback bursts with NACK plus STOP and checks that the pop count equals the bytes read. On every idle clock the routing outputs are compared with a model decoded from that register image.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int NUM_IN = 6;
    localparam int SEL_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        PORT_NONE, PORT_CTRL, PORT_RB
    } port_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_ev_t;

    // sparse selector code -> one-hot over inputs (bit n-1 = input n)
    function automatic logic [NUM_IN-1:0] sel_to_onehot(input logic [SEL_W-1:0] code);
        logic [NUM_IN-1:0] oh;
        case (code)
            4'b0001: oh = 6'b000001;
            4'b0010: oh = 6'b000010;
            4'b1100: oh = 6'b000100;
            4'b0100: oh = 6'b001000;
            4'b0101: oh = 6'b010000;
            4'b0110: oh = 6'b100000;
            default: oh = '0;
        endcase
        return oh;
    endfunction

    // inputs physically reachable by each converter channel
    function automatic logic [NUM_IN-1:0] chan_reach(input int ch);
        logic [NUM_IN-1:0] m;
        case (ch)
            2:       m = 6'b111010;
            3:       m = 6'b001000;
            default: m = 6'b111111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    localparam int SYNC_D = 3;

    logic [SYNC_D-1:0] scl_sh, sda_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_D-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_D-2:0], sda_in};
        end
    end

    always_comb begin
        ev.sda   = sda_sh[SYNC_D-2];
        ev.rise  =  scl_sh[SYNC_D-2] & ~scl_sh[SYNC_D-1];
        ev.fall  = ~scl_sh[SYNC_D-2] &  scl_sh[SYNC_D-1];
        ev.start =  scl_sh[SYNC_D-2] &  scl_sh[SYNC_D-1] & ~sda_sh[SYNC_D-2] &  sda_sh[SYNC_D-1];
        ev.stop  =  scl_sh[SYNC_D-2] &  scl_sh[SYNC_D-1] &  sda_sh[SYNC_D-2] & ~sda_sh[SYNC_D-1];
    end

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] CTRL_ADDR = 7'h20,
    parameter logic [6:0] RB_ADDR   = 7'h10
)(
    input  logic       clk,
    input  logic       rst_n,
    input  line_ev_t   ev,
    input  logic       strap,
    output logic       sda_oe,
    output logic       ptr_set,
    output logic       wr_stb,
    output logic       rd_stb,
    output logic [7:0] rx_byte,
    input  logic [7:0] reg_rd_data,
    output logic       rb_pop,
    input  logic [7:0] rb_data
);
    bus_st_e    st;
    port_e      port;
    logic [2:0] cnt;
    logic [7:0] shreg, txsh;
    logic       full, is_read, first_byte, mack_ok, sda_oe_q;

    logic [6:0] ctrl_a, rb_a;
    logic       hit_ctrl, hit_rb, rx_done, load_evt;
    logic [7:0] tx_byte;

    always_comb begin
        ctrl_a   = {CTRL_ADDR[6:1], CTRL_ADDR[0] | strap};
        rb_a     = {RB_ADDR[6:1],   RB_ADDR[0]   | strap};
        hit_ctrl = (shreg[7:1] == ctrl_a);
        hit_rb   = (shreg[7:1] == rb_a) && shreg[0];
        rx_done  = (st == ST_RX) && ev.fall && full;
        load_evt = ev.fall && (((st == ST_ACK) && is_read) || ((st == ST_MACK) && mack_ok));
        tx_byte  = (port == PORT_RB) ? rb_data : reg_rd_data;
    end

    assign ptr_set = rx_done &&  first_byte;
    assign wr_stb  = rx_done && !first_byte;
    assign rd_stb  = load_evt && (port == PORT_CTRL);
    assign rb_pop  = load_evt && (port == PORT_RB);
    assign rx_byte = shreg;
    assign sda_oe  = sda_oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; port <= PORT_NONE; cnt <= '0; shreg <= '0; txsh <= '0;
            full <= 1'b0; is_read <= 1'b0; first_byte <= 1'b0; mack_ok <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (ev.start) begin
            st <= ST_ADDR; cnt <= '0; full <= 1'b0; sda_oe_q <= 1'b0;
        end else if (ev.stop) begin
            st <= ST_IDLE; sda_oe_q <= 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_RX: begin
                    if (ev.rise) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) full <= 1'b1;
                    end else if (ev.fall && full) begin
                        full <= 1'b0;
                        cnt  <= '0;
                        if (st == ST_RX) begin
                            st <= ST_ACK; sda_oe_q <= 1'b1; first_byte <= 1'b0;
                        end else if (hit_ctrl || hit_rb) begin
                            st         <= ST_ACK;
                            sda_oe_q   <= 1'b1;
                            port       <= hit_ctrl ? PORT_CTRL : PORT_RB;
                            is_read    <= shreg[0];
                            first_byte <= ~shreg[0];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: if (ev.fall) begin
                    if (is_read) begin
                        txsh <= tx_byte; sda_oe_q <= ~tx_byte[7]; cnt <= '0; st <= ST_TX;
                    end else begin
                        sda_oe_q <= 1'b0; st <= ST_RX;
                    end
                end
                ST_TX: if (ev.fall) begin
                    if (cnt == 3'd7) begin
                        sda_oe_q <= 1'b0; st <= ST_MACK;
                    end else begin
                        txsh <= {txsh[6:0], 1'b0}; sda_oe_q <= ~txsh[6]; cnt <= cnt + 3'd1;
                    end
                end
                ST_MACK: begin
                    if (ev.rise) mack_ok <= ~ev.sda;
                    else if (ev.fall) begin
                        if (mack_ok) begin
                            txsh <= tx_byte; sda_oe_q <= ~tx_byte[7]; cnt <= '0; st <= ST_TX;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: one buffer fetch per transmitted byte, never back to back
    p_pop_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rb_pop |=> !rb_pop);
    // R12: idle target keeps SDA released
    p_idle_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe_q);

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import i2c_tgt_pkg::*;
#(
    parameter int         NUM_REGS = 16,
    parameter int         NUM_CH   = 4,
    parameter logic [7:0] EN_REG   = 8'h0C,
    parameter int         EN_BIT   = 7,
    parameter logic [7:0] SEL_REG  = 8'h0D
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ptr_set,
    input  logic                         wr_stb,
    input  logic                         rd_stb,
    input  logic [7:0]                   rx_byte,
    output logic [7:0]                   rd_data,
    output logic                         man_en,
    output logic [NUM_CH-1:0][SEL_W-1:0] sel
);
    localparam int IDXW = $clog2(NUM_REGS);
    localparam int PER_REG = 8 / SEL_W;

    logic [7:0] regs [NUM_REGS];
    logic [7:0] ptr;
    logic       in_range;

    assign in_range = (ptr < 8'(NUM_REGS));
    assign rd_data  = in_range ? regs[ptr[IDXW-1:0]] : 8'h00;
    assign man_en   = regs[EN_REG[IDXW-1:0]][EN_BIT];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
        localparam logic [7:0] RIDX = SEL_REG + 8'(k / PER_REG);
        assign sel[k] = regs[RIDX[IDXW-1:0]][(k % PER_REG)*SEL_W +: SEL_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (ptr_set) begin
            ptr <= rx_byte;
        end else if (wr_stb) begin
            if (in_range) regs[ptr[IDXW-1:0]] <= rx_byte;
            ptr <= ptr + 8'd1;
        end else if (rd_stb) begin
            ptr <= ptr + 8'd1;
        end
    end

    // R4: pointer follows the first byte, then steps once per access
    p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_set |=> (ptr == $past(rx_byte)));
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_stb) |=> (ptr == $past(ptr) + 8'd1));

endmodule

// File: rtl/route_decoder.sv
module route_decoder
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_CH = 4
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         man_en,
    input  logic [NUM_CH-1:0][SEL_W-1:0] sel,
    output logic [NUM_CH*NUM_IN-1:0]     route
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [NUM_IN-1:0] oh;
        assign oh = sel_to_onehot(sel[k]) & chan_reach(k);
        assign route[k*NUM_IN +: NUM_IN] = man_en ? oh : '0;

        // R8: at most one input per channel
        p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(route[k*NUM_IN +: NUM_IN]));
    end

endmodule

// File: rtl/dual_port_i2c_target.sv
module dual_port_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] CTRL_ADDR = 7'h20,
    parameter logic [6:0] RB_ADDR   = 7'h10,
    parameter int         NUM_REGS  = 16,
    parameter int         NUM_CH    = 4,
    localparam int        ROUTE_W   = NUM_CH * NUM_IN
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_strap,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic               rb_pop,
    input  logic [7:0]         rb_data,
    output logic [ROUTE_W-1:0] route_out
);
    line_ev_t                    ev;
    logic                        ptr_set, wr_stb, rd_stb, man_en;
    logic [7:0]                  rx_byte, reg_rd_data;
    logic [NUM_CH-1:0][SEL_W-1:0] sel;

    i2c_line_cond u_line (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    i2c_byte_fsm #(.CTRL_ADDR(CTRL_ADDR), .RB_ADDR(RB_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ev(ev), .strap(addr_strap), .sda_oe(sda_oe),
        .ptr_set(ptr_set), .wr_stb(wr_stb), .rd_stb(rd_stb), .rx_byte(rx_byte),
        .reg_rd_data(reg_rd_data), .rb_pop(rb_pop), .rb_data(rb_data)
    );

    ctrl_reg_bank #(.NUM_REGS(NUM_REGS), .NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .ptr_set(ptr_set), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .rx_byte(rx_byte), .rd_data(reg_rd_data), .man_en(man_en), .sel(sel)
    );

    route_decoder #(.NUM_CH(NUM_CH)) u_route (
        .clk(clk), .rst_n(rst_n), .man_en(man_en), .sel(sel), .route(route_out)
    );

    // R10: manual enable off forces every channel to no input
    p_route_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !man_en |-> (route_out == '0));

endmodule

// File: tb/test_dual_port_i2c_target.sv
module test_dual_port_i2c_target;

    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        sda_oe, rb_pop;
    logic [7:0]  rb_data;
    logic [23:0] route_out;
    wire         sda_bus = m_sda & ~sda_oe;

    int tests = 0, fails = 0, cont_fail = 0, pops = 0, rb_idx = 0;
    bit cmp_on = 1'b0;
    logic [7:0] mreg [16];
    int         mptr = 0;
    logic [7:0] rb_mem [16];

    always #4 clk = ~clk;

    assign rb_data = rb_mem[rb_idx[3:0]];

    dual_port_i2c_target i_dual_port_i2c_target (
        .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .rb_pop(rb_pop), .rb_data(rb_data), .route_out(route_out)
    );

    always @(posedge clk) if (rb_pop) begin rb_idx <= rb_idx + 1; pops <= pops + 1; end

    // behavioural routing model from the register image
    function automatic logic [23:0] mroute();
        logic [23:0] r = '0;
        if (mreg[12][7]) begin
            for (int ch = 0; ch < 4; ch++) begin
                logic [3:0] c = (ch < 2) ? mreg[13] >> (4*ch) : mreg[14] >> (4*(ch-2));
                int inp = 0;
                if (c == 4'd1) inp = 1; else if (c == 4'd2) inp = 2;
                else if (c == 4'd12) inp = 3; else if (c == 4'd4) inp = 4;
                else if (c == 4'd5) inp = 5; else if (c == 4'd6) inp = 6;
                if (ch == 2 && (inp == 1 || inp == 3)) inp = 0;
                if (ch == 3 && inp != 4) inp = 0;
                if (inp != 0) r[ch*6 + inp - 1] = 1'b1;
            end
        end
        return r;
    endfunction

    always @(negedge clk) if (cmp_on && rst_n && route_out !== mroute()) cont_fail++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n*Q) @(negedge clk);
    endtask

    task automatic bus_start();
        cmp_on = 1'b0;
        m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b0; qw(1); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        qw(1); m_sda = 1'b0; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b1; qw(2);
        cmp_on = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            qw(1); m_sda = b[i]; qw(1); m_scl = 1'b1; qw(2); m_scl = 1'b0;
        end
        qw(1); m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); ack = (sda_bus == 1'b0);
        qw(1); m_scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            qw(1); m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); b[i] = sda_bus; qw(1); m_scl = 1'b0;
        end
        qw(1); m_sda = give_ack ? 1'b0 : 1'b1; qw(1); m_scl = 1'b1; qw(2); m_scl = 1'b0;
    endtask

    // control write: address, pointer, data; model updated only when acked
    task automatic ctrl_write(input logic [7:0] dev, input logic [7:0] p,
                              input logic [7:0] d[$], output bit dev_ack, output bit all_ack);
        bit a;
        bus_start();
        send_byte(dev, dev_ack);
        all_ack = dev_ack;
        send_byte(p, a); all_ack &= a;
        foreach (d[i]) begin send_byte(d[i], a); all_ack &= a; end
        bus_stop();
        if (dev_ack) begin
            mptr = p;
            foreach (d[i]) begin if (mptr < 16) mreg[mptr] = d[i]; mptr = (mptr + 1) % 256; end
        end
    endtask

    // set pointer, repeated START, read n bytes; compare with model
    task automatic ctrl_read_chk(input logic [7:0] dev, input logic [7:0] p, input int n,
                                 input string req);
        bit a1, a2;
        logic [7:0] b;
        bus_start();
        send_byte(dev, a1);
        send_byte(p, a2);
        bus_start();
        send_byte(dev | 8'h01, a1);
        check(a1 && a2, req, "ctrl read address ack", a1, 1);
        mptr = p;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n-1, b);
            check(b === ((mptr < 16) ? mreg[mptr] : 8'h00), req, "ctrl read byte",
                  b, (mptr < 16) ? mreg[mptr] : 8'h00);
            mptr = (mptr + 1) % 256;
        end
        bus_stop();
    endtask

    task automatic rb_read_chk(input logic [7:0] dev, input int n, input string req);
        bit a;
        logic [7:0] b;
        int p0 = pops, i0 = rb_idx;
        bus_start();
        send_byte(dev, a);
        check(a, req, "readback address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n-1, b);
            check(b === rb_mem[(i0 + i) % 16], req, "readback byte", b, rb_mem[(i0 + i) % 16]);
        end
        bus_stop();
        qw(4);
        check(pops - p0 == n, req, "pops per burst", pops - p0, n);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
        mptr = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        bit da, aa;
        for (int i = 0; i < 16; i++) rb_mem[i] = 8'(8'h3B * i + 8'h17);
        do_reset();
        cmp_on = 1'b1;

        // R11: reset state
        check(route_out == '0 && !sda_oe && !rb_pop, "R11", "reset outputs", route_out, 0);

        // R1 / R7 / R4 / R8: legal codes on all channels, single burst write
        ctrl_write(8'h40, 8'h0C, '{8'h80, 8'hC1, 8'h46}, da, aa);
        check(da && aa, "R7", "acks on address and data (strap 0)", {da, aa}, 2'b11);
        check(da, "R1", "control write address 0x40", da, 1);
        check(route_out == 24'h220101, "R8", "decode 1/3/6/4", route_out, 24'h220101);
        ctrl_read_chk(8'h40, 8'h0C, 3, "R4");
        check(!sda_oe, "R12", "released after stop", sda_oe, 0);

        // R9: illegal pairings and unsupported codes
        ctrl_write(8'h40, 8'h0D, '{8'h53, 8'h51}, da, aa);
        check(route_out == 24'h000400, "R9", "unsupported and illegal codes", route_out, 24'h000400);
        ctrl_write(8'h40, 8'h0E, '{8'h4C}, da, aa);
        check(route_out == 24'h200400, "R9", "ch2 input3 blocked, ch3 input4", route_out, 24'h200400);
        ctrl_write(8'h40, 8'h0E, '{8'h42}, da, aa);
        check(route_out == 24'h202400, "R8", "ch2 input2", route_out, 24'h202400);

        // R10: enable clear with other bits set
        ctrl_write(8'h40, 8'h0C, '{8'h7F}, da, aa);
        check(route_out == '0, "R10", "manual enable off", route_out, 0);
        ctrl_write(8'h40, 8'h0C, '{8'h80}, da, aa);
        check(route_out == 24'h202400, "R10", "enable restored", route_out, 24'h202400);

        // R5: end of map, writes dropped, reads zero
        ctrl_write(8'h40, 8'h0F, '{8'h9A, 8'h77}, da, aa);
        ctrl_read_chk(8'h40, 8'h0F, 3, "R5");

        // R3: unmatched address and write to readback port are ignored
        ctrl_write(8'h44, 8'h0D, '{8'hFF}, da, aa);
        check(!da, "R3", "unmatched address nack", da, 0);
        ctrl_write(8'h20, 8'h0D, '{8'hFF}, da, aa);
        check(!da, "R3", "write to readback address nack", da, 0);
        check(!sda_oe, "R12", "released after nack", sda_oe, 0);
        ctrl_read_chk(8'h40, 8'h0D, 2, "R3");

        // R6 / R1: readback port
        rb_read_chk(8'h21, 3, "R6");
        rb_read_chk(8'h21, 1, "R6");
        check(!sda_oe, "R12", "released after read", sda_oe, 0);

        // R2: strap 1 address pair
        strap = 1'b1;
        qw(2);
        ctrl_write(8'h40, 8'h0D, '{8'h00}, da, aa);
        check(!da, "R2", "0x40 ignored with strap 1", da, 0);
        ctrl_write(8'h42, 8'h0D, '{8'h45}, da, aa);
        check(da && aa, "R2", "0x42 write acked", {da, aa}, 2'b11);
        ctrl_read_chk(8'h42, 8'h0C, 3, "R2");
        bus_start(); send_byte(8'h21, da); bus_stop();
        check(!da, "R2", "0x21 ignored with strap 1", da, 0);
        rb_read_chk(8'h23, 2, "R2");

        // R11: reset after configuration
        do_reset();
        check(route_out == '0, "R11", "routing cleared", route_out, 0);
        ctrl_write(8'h42, 8'h0C, '{8'h80}, da, aa);
        check(route_out == '0, "R11", "selectors cleared", route_out, 0);
        ctrl_read_chk(8'h42, 8'h0C, 4, "R11");

        check(cont_fail == 0, "R8", "per-clock route vs model", cont_fail, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule